// File: doc/BRIEF.md
# Round-Robin Warp Issue Scheduler

This block chooses, in every clock cycle, at most one warp from a fixed pool of hardware warp contexts to send into the execution pipeline. Selection is fair: a rotating pointer gives first claim to the warp just after the one most recently issued, and the search wraps around the pool. Every warp keeps its register context resident, so moving from one warp to another costs no cycles. Each warp can have at most one instruction in flight. This removes the need for dependency checks and operand bypassing between instructions of the same warp.

Two per-warp flags control eligibility. A warp whose issued instruction is ordinary is held back until the pipeline signals writeback for it. A warp whose issued instruction is a long-latency memory access leaves the ready pool until the memory system returns a completion for that warp. Meanwhile the other warps continue to issue. A completion pulse counts before the eligibility check of its own cycle, so a warp can be released and issue again in that same cycle.

The issue side is a valid/ready stream. `issue_valid_o` and `issue_warp_o` are offered without regard to `issue_ready_i`. An issue takes place only on a cycle where both valid and ready are high. While ready is low, no issue flag is set and the pointer holds. Completion pulses are still taken in during those cycles.

Top module: `warp_issue_sched`

## Requirements
- R1: A synchronous reset clears every in-flight and memory-wait flag and sets the pointer to warp 0, so the first issue after reset, with all warps requesting, goes to warp 0.
- R2: `issue_valid_o` is high exactly when at least one warp is eligible, and then `issue_warp_o` names an eligible warp. A warp is eligible when its `warp_valid_i` bit is high and neither of its flags is pending.
- R3: The selected warp is the first eligible warp found when searching upward from the pointer, wrapping from warp NUM_WARPS-1 to warp 0. After an issue the pointer moves to the issued warp plus one, modulo NUM_WARPS.
- R4: When no warp is eligible, `issue_valid_o` is low and the pointer does not move.
- R5: An issued warp whose `warp_long_lat_i` bit was 0 is not eligible again until its `wb_done_i` bit pulses. A pulse in a cycle makes the warp eligible in that same cycle.
- R6: An issued warp whose `warp_long_lat_i` bit was 1 is not eligible until its `mem_done_i` bit pulses, while other warps keep issuing.
- R7: A `mem_done_i` pulse for a warp clears its memory wait before that cycle's selection, so the warp can issue again in the same cycle without deadlock. If that new issue is again long-latency, the wait flag is set again.
- R8: While `issue_ready_i` is low, no flag is set and the pointer holds. The same choice is therefore offered until the handshake completes, provided the inputs are unchanged.
- R9: A `wb_done_i` pulse does not release a warp that is waiting on memory. A done pulse for a warp with nothing outstanding has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| warp_valid_i | input | NUM_WARPS | Per warp: the next instruction is decoded and ready to issue |
| warp_long_lat_i | input | NUM_WARPS | Per warp: the next instruction is a long-latency memory access |
| mem_done_i | input | NUM_WARPS | Per warp: pulse when the outstanding memory access completes |
| wb_done_i | input | NUM_WARPS | Per warp: pulse when the in-flight instruction writes back |
| issue_ready_i | input | 1 | Pipeline accepts an issue this cycle |
| issue_valid_o | output | 1 | An eligible warp is offered |
| issue_warp_o | output | $clog2(NUM_WARPS) | ID of the offered warp |

## Verification
Every warp requesting, with writeback returned at once, produces a strict sequence 0, 1, 2, … that wraps from the last warp. This separates correct rotation from a fixed-priority or off-by-one pointer. Sparse patterns, such as one or two requesting warps and an empty pool, show whether the pointer stays put when idle and whether the search skips over the correct gaps. Withheld and same-cycle completion pulses on memory and writeback separate the two flags from each other, and show that a done counts first in its own cycle. Held-low ready and a long randomized mix of requests, memory flags, dones and back-pressure are compared against a model built from the requirements.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

  // Outstanding-work flags kept for one warp context.
  typedef struct packed {
    logic inflight;  // ordinary instruction waiting for writeback
    logic mem_wait;  // memory access waiting for completion
  } warp_flags_t;

  localparam warp_flags_t FLAGS_CLEAR = '{inflight: 1'b0, mem_wait: 1'b0};

endpackage

// File: rtl/wsched_warp_slot.sv
module wsched_warp_slot
  import warp_sched_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic grant_i,
  input  logic long_lat_i,
  input  logic mem_done_i,
  input  logic wb_done_i,
  output logic eligible_o
);

  warp_flags_t flags_q, flags_d;
  logic inflight_left;
  logic memwait_left;

  // Completions are applied ahead of the eligibility test of the same cycle.
  assign inflight_left = flags_q.inflight & ~wb_done_i;
  assign memwait_left  = flags_q.mem_wait & ~mem_done_i;
  assign eligible_o    = req_i & ~inflight_left & ~memwait_left;

  always_comb begin
    flags_d.inflight = inflight_left | (grant_i & ~long_lat_i);
    flags_d.mem_wait = memwait_left  | (grant_i &  long_lat_i);
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= FLAGS_CLEAR;
    else     flags_q <= flags_d;
  end

endmodule

// File: rtl/wsched_rr_pick.sv
module wsched_rr_pick #(
  parameter int NUM_WARPS = 16,
  localparam int IDW = $clog2(NUM_WARPS),
  localparam int SW  = IDW + 1
) (
  input  logic [NUM_WARPS-1:0] req_i,
  input  logic [IDW-1:0]       ptr_i,
  output logic                 any_o,
  output logic [IDW-1:0]       idx_o
);

  logic [2*NUM_WARPS-1:0] doubled;
  logic [NUM_WARPS-1:0]   rotated;
  logic [IDW-1:0]         offset;
  logic [SW-1:0]          sum;

  assign doubled = {req_i, req_i} >> ptr_i;
  assign rotated = doubled[NUM_WARPS-1:0];
  assign any_o   = |req_i;

  // Lowest set bit of the rotated vector = nearest request at/after ptr.
  always_comb begin
    offset = '0;
    for (int i = NUM_WARPS - 1; i >= 0; i--) begin
      if (rotated[i]) offset = IDW'(i);
    end
  end

  always_comb begin
    sum = SW'(ptr_i) + SW'(offset);
    if (sum >= SW'(NUM_WARPS)) sum = sum - SW'(NUM_WARPS);
    idx_o = sum[IDW-1:0];
  end

endmodule

// File: rtl/wsched_rr_ptr.sv
module wsched_rr_ptr #(
  parameter int NUM_WARPS = 16,
  localparam int IDW = $clog2(NUM_WARPS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           adv_i,
  input  logic [IDW-1:0] grant_idx_i,
  output logic [IDW-1:0] ptr_o
);

  localparam logic [IDW-1:0] LAST = IDW'(NUM_WARPS - 1);

  always_ff @(posedge clk) begin
    if (rst)        ptr_o <= '0;
    else if (adv_i) ptr_o <= (grant_idx_i == LAST) ? '0 : grant_idx_i + 1'b1;
  end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int NUM_WARPS = 16,
  localparam int IDW = $clog2(NUM_WARPS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_WARPS-1:0] warp_valid_i,
  input  logic [NUM_WARPS-1:0] warp_long_lat_i,
  input  logic [NUM_WARPS-1:0] mem_done_i,
  input  logic [NUM_WARPS-1:0] wb_done_i,
  input  logic                 issue_ready_i,
  output logic                 issue_valid_o,
  output logic [IDW-1:0]       issue_warp_o
);

  logic [NUM_WARPS-1:0] eligible;
  logic [NUM_WARPS-1:0] grant_vec;
  logic [IDW-1:0]       rr_ptr;
  logic                 fire;

  assign fire = issue_valid_o & issue_ready_i;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
    assign grant_vec[w] = fire & (issue_warp_o == IDW'(w));

    wsched_warp_slot u_slot (
      .clk        (clk),
      .rst        (rst),
      .req_i      (warp_valid_i[w]),
      .grant_i    (grant_vec[w]),
      .long_lat_i (warp_long_lat_i[w]),
      .mem_done_i (mem_done_i[w]),
      .wb_done_i  (wb_done_i[w]),
      .eligible_o (eligible[w])
    );
  end

  wsched_rr_pick #(.NUM_WARPS(NUM_WARPS)) u_pick (
    .req_i (eligible),
    .ptr_i (rr_ptr),
    .any_o (issue_valid_o),
    .idx_o (issue_warp_o)
  );

  wsched_rr_ptr #(.NUM_WARPS(NUM_WARPS)) u_ptr (
    .clk         (clk),
    .rst         (rst),
    .adv_i       (fire),
    .grant_idx_i (issue_warp_o),
    .ptr_o       (rr_ptr)
  );

endmodule

// File: rtl/warp_issue_sched_chk.sv
module warp_issue_sched_chk #(
  parameter int NUM_WARPS = 16,
  localparam int IDW = $clog2(NUM_WARPS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_WARPS-1:0] warp_valid_i,
  input logic [NUM_WARPS-1:0] warp_long_lat_i,
  input logic [NUM_WARPS-1:0] mem_done_i,
  input logic [NUM_WARPS-1:0] wb_done_i,
  input logic                 issue_ready_i,
  input logic                 issue_valid_o,
  input logic [IDW-1:0]       issue_warp_o
);

  logic           fire;
  logic [IDW-1:0] succ_id;

  assign fire    = issue_valid_o & issue_ready_i;
  assign succ_id = (issue_warp_o == IDW'(NUM_WARPS - 1)) ? '0 : issue_warp_o + 1'b1;

  AST_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (rst)
    issue_valid_o |-> warp_valid_i[issue_warp_o]); // R2

  AST_IDLE_NO_ISSUE: assert property (@(posedge clk) disable iff (rst)
    (warp_valid_i == '0) |-> !issue_valid_o); // R4

  AST_ROTATE_NEXT: assert property (@(posedge clk) disable iff (rst)
    (!rst && fire) |=> ((&warp_valid_i) && (&wb_done_i) && (&mem_done_i))
                       -> (issue_warp_o == $past(succ_id))); // R3

  AST_WB_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (!rst && fire && !warp_long_lat_i[issue_warp_o]) |=>
      (!(issue_valid_o && issue_warp_o == $past(issue_warp_o)) || wb_done_i[$past(issue_warp_o)])); // R5

  AST_MEM_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (!rst && fire && warp_long_lat_i[issue_warp_o]) |=>
      (!(issue_valid_o && issue_warp_o == $past(issue_warp_o)) || mem_done_i[$past(issue_warp_o)])); // R6

endmodule

bind warp_issue_sched warp_issue_sched_chk #(.NUM_WARPS(NUM_WARPS)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .warp_valid_i    (warp_valid_i),
  .warp_long_lat_i (warp_long_lat_i),
  .mem_done_i      (mem_done_i),
  .wb_done_i       (wb_done_i),
  .issue_ready_i   (issue_ready_i),
  .issue_valid_o   (issue_valid_o),
  .issue_warp_o    (issue_warp_o)
);

// File: tb/warp_issue_sched_tb.sv
`timescale 1ns/1ps
module warp_issue_sched_tb;

  localparam int N  = 16;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  warp_valid_i, warp_long_lat_i, mem_done_i, wb_done_i;
  logic          issue_ready_i;
  logic          issue_valid_o;
  logic [IW-1:0] issue_warp_o;

  always #2 clk = ~clk;  // 250 MHz

  warp_issue_sched #(.NUM_WARPS(N)) u_dut (
    .clk             (clk),
    .rst             (rst),
    .warp_valid_i    (warp_valid_i),
    .warp_long_lat_i (warp_long_lat_i),
    .mem_done_i      (mem_done_i),
    .wb_done_i       (wb_done_i),
    .issue_ready_i   (issue_ready_i),
    .issue_valid_o   (issue_valid_o),
    .issue_warp_o    (issue_warp_o)
  );

  typedef struct {
    logic          v;
    logic [IW-1:0] id;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   finished = 0;

  // Requirement model
  logic [N-1:0]  m_infl, m_blk;
  int            m_ptr;
  logic          m_v;
  int            m_id;

  task automatic model_eval();
    logic [N-1:0] el;
    el = warp_valid_i & ~(m_infl & ~wb_done_i) & ~(m_blk & ~mem_done_i);
    m_v = 1'b0; m_id = 0;
    for (int i = 0; i < N; i++) begin
      int k;
      k = (m_ptr + i) % N;
      if (!m_v && el[k]) begin m_v = 1'b1; m_id = k; end
    end
  endtask

  task automatic model_update();
    logic f;
    f = m_v && issue_ready_i;
    m_infl = m_infl & ~wb_done_i;
    m_blk  = m_blk  & ~mem_done_i;
    if (f) begin
      if (warp_long_lat_i[m_id]) m_blk[m_id]  = 1'b1;
      else                       m_infl[m_id] = 1'b1;
      m_ptr = (m_id + 1) % N;
    end
  endtask

  // Driver: push expectation for the current inputs, then advance one clock.
  task automatic step(input string tag);
    exp_t e;
    model_eval();
    e.v = m_v; e.id = IW'(m_id); e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    model_update();
    @(posedge clk); #1;
  endtask

  task automatic set_in(input logic [N-1:0] v, input logic [N-1:0] ll,
                        input logic [N-1:0] md, input logic [N-1:0] wb, input logic rdy);
    warp_valid_i = v; warp_long_lat_i = ll; mem_done_i = md; wb_done_i = wb; issue_ready_i = rdy;
  endtask

  // Monitor: compare offered issue against the expectation.
  initial begin
    forever begin
      @(negedge clk); #0.5;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_checks++;
        if (issue_valid_o !== e.v || (e.v && issue_warp_o !== e.id)) begin
          n_fail++;
          $display("FAIL %s: got valid=%0b warp=%0d, expected valid=%0b warp=%0d",
                   e.tag, issue_valid_o, issue_warp_o, e.v, e.id);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got running, expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    set_in('0, '0, '0, '0, 1'b1);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    m_infl = '0; m_blk = '0; m_ptr = 0;

    // R1: first issue after reset goes to warp 0
    set_in('1, '0, '1, '1, 1'b1);
    step("R1");

    // R3: full pool, immediate writeback -> strict rotation with wrap
    for (int c = 0; c < 20; c++) step("R3");

    // R4: empty pool, pointer must hold; then sparse request
    set_in('0, '0, '0, '0, 1'b1);
    for (int c = 0; c < 3; c++) step("R4");
    set_in(N'(1) << 5 | N'(1) << 2, '0, '0, '0, 1'b1);
    step("R4");
    step("R3");

    // R5: lone warp 3, no writeback -> single issue then idle; same-cycle release
    set_in(N'(1) << 3, '0, '0, '0, 1'b1);
    step("R5"); step("R5"); step("R5");
    set_in(N'(1) << 3, '0, '0, N'(1) << 3, 1'b1);
    step("R5");
    set_in(N'(1) << 3, '0, '0, '0, 1'b1);
    step("R5");

    // R6: warp 2 memory, warp 7 ordinary with writeback on; 7 keeps issuing
    set_in((N'(1) << 2) | (N'(1) << 7), N'(1) << 2, '0, '1, 1'b1);
    for (int c = 0; c < 5; c++) step("R6");
    // R9: writeback does not release a memory wait
    step("R9");
    // R7: memory done and re-issue in one cycle, re-blocks on long latency
    set_in(N'(1) << 2, N'(1) << 2, N'(1) << 2, '0, 1'b1);
    step("R7");
    set_in(N'(1) << 2, N'(1) << 2, '0, '1, 1'b1);
    step("R7"); step("R7");
    set_in(N'(1) << 2, '0, N'(1) << 2, '0, 1'b1);
    step("R7");

    // R9: stray dones for idle warps change nothing
    set_in('0, '0, '1, '1, 1'b1);
    step("R9"); step("R9");
    set_in(N'(1) << 9 | N'(1) << 12, '0, '0, '1, 1'b1);
    step("R9"); step("R9");

    // R8: back-pressure holds the offer and state
    set_in('1, '0, '0, '1, 1'b0);
    for (int c = 0; c < 4; c++) step("R8");
    issue_ready_i = 1'b1;
    step("R8"); step("R8");

    // R2: randomized mix against the model
    for (int c = 0; c < 400; c++) begin
      set_in(N'($urandom), N'($urandom) & N'($urandom), N'($urandom), N'($urandom),
             ($urandom % 4) != 0);
      step("R2");
    end

    @(negedge clk); #1;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule